// File: doc/BRIEF.md
# Quad-Channel Converter Command Receiver

This block is the digital front end of a four-channel, 8-bit converter. A host drives three serial pins (a shift clock, a data line and a load strobe) plus a separate active-low update strobe. The block samples all four pins with a fast system clock through two-flop synchronizers and detects their edges. It shifts in 11-bit command words and decodes a channel address. It then holds each channel's code and span flag in a pair of latches: an input latch and an output latch. The output latches drive analog converters that sit outside the block.

A falling edge on the load strobe copies the last word received into the input latch of the addressed channel. If the update strobe is low at that moment, the output latch of that channel follows straight away. If the update strobe is high, the outputs keep their values until the update strobe falls, and then all four output latches take their input latches together. A small state machine controls the sequence. It has three states. `RX_HOLD` waits for the load strobe to be high. `RX_ARMED` accepts serial bits. `RX_LATCH` lasts one cycle and performs the write. The transitions are arm (`RX_HOLD` to `RX_ARMED` when load is seen high), fire (`RX_ARMED` to `RX_LATCH` on a load fall) and done (`RX_LATCH` to `RX_HOLD` unconditionally). The system clock must run at least eight times faster than the shift clock.

Top module: `qdac_cmd_rx`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output code, every span flag, every input latch and the shift register are cleared to zero.
- R2: A bit is taken from `ser_data` on each falling edge of `ser_clk` seen while the receiver is armed, that is, after `ser_load` has been seen high. Bits arrive most significant first. Word bit 10 is the first bit and word bit 0 is the last. The word layout is address [10:9], span flag [8] and code [7:0].
- R3: The address field selects the channel: 0 is channel 0 (`dac_code[7:0]`, `dac_range[0]`), 1 is channel 1, 2 is channel 2 and 3 is channel 3 (`dac_code[31:24]`, `dac_range[3]`).
- R4: When `upd_n` is low as `ser_load` falls, only the addressed channel's output code and span flag change, and they take the word's code and span flag.
- R5: When `upd_n` is high as `ser_load` falls, no output changes.
- R6: A falling edge on `upd_n` copies all four input latches to the four output latches in the same cycle.
- R7: Only the last 11 bits shifted before `ser_load` falls are used. Earlier bits in a longer burst have no effect.
- R8: A span flag of 1 in the word makes `dac_range` 1 for that channel, which stands for a twice-reference span. A flag of 0 stands for a once-reference span.
- R9: `ser_clk` edges that occur after `ser_load` has fallen and before it is seen high again shift nothing. A second load fall with no new bits rewrites the same word.
- R10: A falling `ser_load` pin with `upd_n` low updates the output on the 4th rising clock edge after the pin change. A falling `upd_n` pin updates the outputs on the 3rd rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_load | input | 1 | Load strobe; its falling edge writes the input latch |
| upd_n | input | 1 | Active-low update strobe for the output latches |
| dac_code | output | 32 | Four 8-bit output codes; channel n is in bits [8n+7:8n] |
| dac_range | output | 4 | Span flag per channel; 1 means twice the reference |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit codes and two synchronizer stages. With these values every address decode and the top code and flag bits can be reached. The shift clock runs at one tenth of the system clock, close to the 8x floor, so the synchronizer latency of each edge is exercised near its limit. A behavioural model fed by the same pin samples predicts every output on every cycle. Directed checks then pin down the order of the address, flag and code fields, the 16-bit burst with leading junk bits, clock edges while load is low, and the exact edge counts of R10.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        RX_HOLD  = 2'd0,
        RX_ARMED = 2'd1,
        RX_LATCH = 2'd2
    } rx_state_e;

    localparam int PIN_SCLK = 0;
    localparam int PIN_DATA = 1;
    localparam int PIN_LOAD = 2;
    localparam int PIN_UPD  = 3;
    localparam int NUM_PINS = 4;

endpackage

// File: rtl/qdac_pin_sync.sv
module qdac_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
        end
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
    parameter int WORD_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (en) begin
            word <= {word[WORD_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/qdac_rx_fsm.sv
module qdac_rx_fsm
    import qdac_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 8,
    parameter int ADDR_W = 2,
    parameter int WORD_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall,
    input  logic              load_fall,
    input  logic              load_lvl,
    input  logic              upd_lvl,
    input  logic [WORD_W-1:0] word,
    output logic              shift_en,
    output logic [NUM_CH-1:0] wr_en,
    output logic              wr_imm,
    output logic [CODE_W-1:0] wr_code,
    output logic              wr_rng
);
    rx_state_e          state_q;
    rx_state_e          state_d;
    logic [ADDR_W-1:0]  addr;

    // Field positions matter: address on top, span flag, then code.
    assign addr    = word[WORD_W-1 -: ADDR_W];
    assign wr_rng  = word[CODE_W];
    assign wr_code = word[CODE_W-1:0];

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: arm, fire, done.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HOLD:  if (load_lvl)  state_d = RX_ARMED;
            RX_ARMED: if (load_fall) state_d = RX_LATCH;
            RX_LATCH: state_d = RX_HOLD;
            default:  state_d = RX_HOLD;
        endcase
    end

    // Outputs.
    always_comb begin
        shift_en = 1'b0;
        wr_en    = '0;
        wr_imm   = 1'b0;
        unique case (state_q)
            RX_HOLD:  ;
            RX_ARMED: shift_en = sclk_fall;
            RX_LATCH: begin
                wr_en[addr] = 1'b1;
                wr_imm      = ~upd_lvl;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/qdac_chan_reg.sv
module qdac_chan_reg #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              imm,
    input  logic              commit,
    input  logic [CODE_W-1:0] new_code,
    input  logic              new_rng,
    output logic [CODE_W-1:0] code,
    output logic              rng
);
    logic [CODE_W-1:0] in_code;
    logic              in_rng;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_code <= '0;
            in_rng  <= 1'b0;
            code    <= '0;
            rng     <= 1'b0;
        end else begin
            if (wr) begin
                in_code <= new_code;
                in_rng  <= new_rng;
            end
            if (commit) begin
                code <= wr ? new_code : in_code;
                rng  <= wr ? new_rng  : in_rng;
            end else if (wr && imm) begin
                code <= new_code;
                rng  <= new_rng;
            end
        end
    end
endmodule

// File: rtl/qdac_cmd_rx.sv
module qdac_cmd_rx
    import qdac_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_data,
    input  logic                     ser_load,
    input  logic                     upd_n,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        dac_range
);
    localparam int ADDR_W = $clog2(NUM_CH);
    localparam int WORD_W = ADDR_W + 1 + CODE_W;

    logic [NUM_PINS-1:0] pin_raw;
    logic [NUM_PINS-1:0] pin_lvl;
    logic                sclk_prev, load_prev, upd_prev;
    logic                sclk_fall, load_fall, commit;
    logic                shift_en;
    logic [WORD_W-1:0]   word;
    logic [NUM_CH-1:0]   wr_en;
    logic                wr_imm;
    logic [CODE_W-1:0]   wr_code;
    logic                wr_rng;

    assign pin_raw[PIN_SCLK] = ser_clk;
    assign pin_raw[PIN_DATA] = ser_data;
    assign pin_raw[PIN_LOAD] = ser_load;
    assign pin_raw[PIN_UPD]  = upd_n;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_sync
        qdac_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_raw[p]),
            .level (pin_lvl[p])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            load_prev <= 1'b0;
            upd_prev  <= 1'b0;
        end else begin
            sclk_prev <= pin_lvl[PIN_SCLK];
            load_prev <= pin_lvl[PIN_LOAD];
            upd_prev  <= pin_lvl[PIN_UPD];
        end
    end

    assign sclk_fall = sclk_prev & ~pin_lvl[PIN_SCLK];
    assign load_fall = load_prev & ~pin_lvl[PIN_LOAD];
    assign commit    = upd_prev  & ~pin_lvl[PIN_UPD];

    qdac_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (shift_en),
        .bit_in (pin_lvl[PIN_DATA]),
        .word   (word)
    );

    qdac_rx_fsm #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W),
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_fall (sclk_fall),
        .load_fall (load_fall),
        .load_lvl  (pin_lvl[PIN_LOAD]),
        .upd_lvl   (pin_lvl[PIN_UPD]),
        .word      (word),
        .shift_en  (shift_en),
        .wr_en     (wr_en),
        .wr_imm    (wr_imm),
        .wr_code   (wr_code),
        .wr_rng    (wr_rng)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        qdac_chan_reg #(.CODE_W(CODE_W)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_en[c]),
            .imm      (wr_imm),
            .commit   (commit),
            .new_code (wr_code),
            .new_rng  (wr_rng),
            .code     (dac_code[c*CODE_W +: CODE_W]),
            .rng      (dac_range[c])
        );
    end
endmodule

// File: rtl/qdac_cmd_rx_checker.sv
module qdac_cmd_rx_checker #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 8,
    parameter int WORD_W = 11
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        wr_en,
    input logic                     wr_imm,
    input logic                     commit,
    input logic [CODE_W-1:0]        wr_code,
    input logic                     wr_rng,
    input logic                     shift_en,
    input logic                     data_lvl,
    input logic [WORD_W-1:0]        word,
    input logic [NUM_CH*CODE_W-1:0] dac_code,
    input logic [NUM_CH-1:0]        dac_range
);
    p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    p_outputs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit || ((|wr_en) && wr_imm)) |=> ($stable(dac_code) && $stable(dac_range)));

    p_shift_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word));

    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word[0] == $past(data_lvl)));

    p_write_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en) |=> !(|wr_en));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_direct_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[c] && wr_imm) |=>
                (dac_code[c*CODE_W +: CODE_W] == $past(wr_code) && dac_range[c] == $past(wr_rng)));
    end
endmodule

bind qdac_cmd_rx qdac_cmd_rx_checker #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .WORD_W (WORD_W)
) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_imm    (wr_imm),
    .commit    (commit),
    .wr_code   (wr_code),
    .wr_rng    (wr_rng),
    .shift_en  (shift_en),
    .data_lvl  (pin_lvl[1]),
    .word      (word),
    .dac_code  (dac_code),
    .dac_range (dac_range)
);

// File: tb/test_qdac_cmd_rx.sv
module test_qdac_cmd_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_load = 1'b1;
    logic        upd_n = 1'b1;
    logic [31:0] dac_code;
    logic [3:0]  dac_range;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    qdac_cmd_rx i_qdac_cmd_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_load  (ser_load),
        .upd_n     (upd_n),
        .dac_code  (dac_code),
        .dac_range (dac_range)
    );

    // ---------------- behavioural reference model ----------------
    int  hs[3], hd[3], hl[3], hu[3];   // pin history, index 0 = newest sample
    int  m_state;                      // 0 waiting, 1 accepting bits, 2 writing
    int  m_word;
    int  m_in_code[4], m_in_rng[4], m_out_code[4], m_out_rng[4];
    bit  m_valid = 0;
    bit  sf, lf, uf;
    int  ch;

    always @(posedge clk) begin
        m_valid = 1;
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin hs[k] = 0; hd[k] = 0; hl[k] = 0; hu[k] = 0; end
            m_state = 0; m_word = 0;
            for (int k = 0; k < 4; k++) begin
                m_in_code[k] = 0; m_in_rng[k] = 0; m_out_code[k] = 0; m_out_rng[k] = 0;
            end
        end else begin
            sf = (hs[1] == 0) && (hs[2] == 1);
            lf = (hl[1] == 0) && (hl[2] == 1);
            uf = (hu[1] == 0) && (hu[2] == 1);
            if (m_state == 2) begin
                ch = (m_word >> 9) & 3;
                m_in_code[ch] = m_word & 255;
                m_in_rng[ch]  = (m_word >> 8) & 1;
                if (!uf && hu[1] == 0) begin
                    m_out_code[ch] = m_in_code[ch];
                    m_out_rng[ch]  = m_in_rng[ch];
                end
            end
            if (uf) begin
                for (int k = 0; k < 4; k++) begin
                    m_out_code[k] = m_in_code[k]; m_out_rng[k] = m_in_rng[k];
                end
            end
            if (m_state == 1 && sf) m_word = ((m_word << 1) | hd[1]) & 12'h7FF;
            case (m_state)
                0: if (hl[1] == 1) m_state = 1;
                1: if (lf) m_state = 2;
                default: m_state = 0;
            endcase
            for (int k = 2; k > 0; k--) begin
                hs[k] = hs[k-1]; hd[k] = hd[k-1]; hl[k] = hl[k-1]; hu[k] = hu[k-1];
            end
            hs[0] = ser_clk; hd[0] = ser_data; hl[0] = ser_load; hu[0] = upd_n;
        end
    end

    always @(negedge clk) begin
        if (m_valid && !done) begin
            logic [31:0] ec;
            logic [3:0]  er;
            for (int k = 0; k < 4; k++) begin
                ec[k*8 +: 8] = m_out_code[k][7:0];
                er[k]        = m_out_rng[k][0];
            end
            checks++;
            if (dac_code !== ec || dac_range !== er) begin
                errors++;
                $display("FAIL per-cycle model (R4 R5 R6 R10): code=%h range=%b expected code=%h range=%b",
                         dac_code, dac_range, ec, er);
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic int code_of(int c);
        return int'(dac_code[c*8 +: 8]);
    endfunction

    task automatic check_val(string tag, int actual, int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic send_bits(logic [31:0] bits, int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_data = bits[i];
            ser_clk  = 1'b1;
            repeat (5) @(negedge clk);
            ser_clk  = 1'b0;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic pulse_load();
        @(negedge clk); ser_load = 1'b0;
        repeat (6) @(negedge clk); ser_load = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_upd();
        @(negedge clk); upd_n = 1'b0;
        repeat (6) @(negedge clk); upd_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // word = {addr[1:0], span, code[7:0]}
    function automatic logic [31:0] mk(int a, int s, int c);
        return {21'd0, 2'(a), 1'(s), 8'(c)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        // R1: reset state
        check_val("R1 codes after reset", int'(dac_code), 0);
        check_val("R1 span flags after reset", int'(dac_range), 0);

        // Immediate mode
        upd_n = 1'b0;
        repeat (6) @(negedge clk);
        send_bits(mk(0, 0, 8'h3C), 11); pulse_load();
        check_val("R2 R4 channel 0 code", code_of(0), 8'h3C);
        check_val("R4 channel 1 untouched", code_of(1), 0);
        check_val("R4 channel 3 untouched", code_of(3), 0);

        send_bits(mk(3, 1, 8'hF0), 11); pulse_load();
        check_val("R3 channel 3 code", code_of(3), 8'hF0);
        check_val("R8 channel 3 span", int'(dac_range[3]), 1);
        check_val("R8 channel 0 span", int'(dac_range[0]), 0);

        // R7: 16-bit burst with five leading ones
        send_bits({16'h0, 5'b11111, mk(2, 0, 8'hA5)[10:0]}, 16); pulse_load();
        check_val("R7 channel 2 code", code_of(2), 8'hA5);
        check_val("R7 channel 2 span", int'(dac_range[2]), 0);
        check_val("R7 channel 3 kept", code_of(3), 8'hF0);

        // R9: clock edges while load is low are ignored
        send_bits(mk(1, 1, 8'h81), 11);
        @(negedge clk); ser_load = 1'b0;
        repeat (6) @(negedge clk);
        ser_data = 1'b1;
        for (int i = 0; i < 3; i++) begin
            ser_clk = 1'b1; repeat (5) @(negedge clk);
            ser_clk = 1'b0; repeat (5) @(negedge clk);
        end
        ser_load = 1'b1; repeat (6) @(negedge clk);
        pulse_load();
        check_val("R9 channel 1 code", code_of(1), 8'h81);
        check_val("R9 channel 1 span", int'(dac_range[1]), 1);
        check_val("R9 channel 0 kept", code_of(0), 8'h3C);
        check_val("R9 channel 2 kept", code_of(2), 8'hA5);
        check_val("R9 channel 3 kept", code_of(3), 8'hF0);

        // Deferred mode
        upd_n = 1'b1;
        repeat (6) @(negedge clk);
        send_bits(mk(0, 1, 8'h11), 11); pulse_load();
        send_bits(mk(2, 0, 8'h22), 11); pulse_load();
        send_bits(mk(3, 0, 8'h07), 11); pulse_load();
        check_val("R5 channel 0 held", code_of(0), 8'h3C);
        check_val("R5 channel 2 held", code_of(2), 8'hA5);
        check_val("R5 channel 3 held", code_of(3), 8'hF0);
        check_val("R5 spans held", int'(dac_range), 4'b1010);
        pulse_upd();
        check_val("R6 channel 0 code", code_of(0), 8'h11);
        check_val("R6 channel 1 code", code_of(1), 8'h81);
        check_val("R6 channel 2 code", code_of(2), 8'h22);
        check_val("R6 channel 3 code", code_of(3), 8'h07);
        check_val("R6 spans", int'(dac_range), 4'b0011);

        // R10: update strobe latency
        send_bits(mk(0, 0, 8'h66), 11); pulse_load();
        @(negedge clk); upd_n = 1'b0;
        lat = 0;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk); #1;
            if (lat == 0 && code_of(0) == 8'h66) lat = k;
        end
        check_val("R10 update strobe latency", lat, 3);

        // R10: load strobe latency, immediate mode
        send_bits(mk(0, 0, 8'h5A), 11);
        @(negedge clk); ser_load = 1'b0;
        lat = 0;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk); #1;
            if (lat == 0 && code_of(0) == 8'h5A) lat = k;
        end
        check_val("R10 load strobe latency", lat, 4);
        @(negedge clk); ser_load = 1'b1;
        repeat (10) @(negedge clk);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_val("R1 codes cleared", int'(dac_code), 0);
        check_val("R1 spans cleared", int'(dac_range), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule